// File: doc/BRIEF.md
# DMA Transfer Queue and Interrupt Tracker

This block keeps the control-side bookkeeping of one DMA channel. Software arms a start bit together with a byte length and a row count, and the block queues the request under a rotating 5-bit transfer ID. Each ID has one bit in a completion bitmap. A simple beat-counting model stands in for the memory mover: it sets the duration of each transfer from the programmed lengths. An external error strobe can end the active transfer early.

The block has two slots: the active transfer and at most one waiting transfer behind it. It raises a start-of-transfer event when a request lands in the active slot and an end-of-transfer event when a transfer finishes or fails. Both events pass through a mask to a single interrupt line. In cyclic mode the active transfer repeats forever and does not raise end-of-transfer. The pause input freezes the transfer in progress. Dropping the enable discards everything that is queued or running.

Top module: `dma_xfer_tracker`

## Requirements
- R1: `next_id_o` is a 5-bit ID that resets to 0 and increments by one, modulo 32, each time a request is taken into a slot.
- R2: A start write with data 1 while enabled sets `start_pend_o`. The bit returns to 0 in the cycle after the request is taken into a slot. A start write with data 0, or any start write while disabled, leaves it at 0.
- R3: Done-bitmap bit N clears when a request with ID N is taken and sets when that transfer completes normally. An error termination does not set it.
- R4: While no transfer is active, `busy_o` is 0 and `active_id_o` equals `next_id_o`. Otherwise `active_id_o` is the ID of the running transfer.
- R5: Source bit 0 (start-of-transfer) sets when a request goes directly into the empty active slot. It does not set when the request goes into the waiting slot.
- R6: Source bit 1 (end-of-transfer) sets on a normal completion outside cyclic mode, and on an error strobe while a transfer is active.
- R7: `irq_pend_o` is the source gated by the inverse of `irq_mask_i`, and `irq_o` is the OR of the pending bits. A 1 on a bit of `irq_clr_i` clears that source bit. If a new event and a clear land in the same cycle, the new event wins.
- R8: In cyclic mode a completing transfer restarts with the same ID and lengths. Its done bit is set, and no end-of-transfer is raised.
- R9: A transfer lasts ((bytes field >> 2) + 1) × (rows field + 1) cycles in which it is not paused, counted from the cycle it becomes active. While `pause_i` is 1 it neither advances nor completes.
- R10: With `enable_i` at 0 the active transfer, the waiting request and the start bit are dropped in the next cycle, and the done bitmap is left unchanged.
- R11: The waiting slot holds one request. That request becomes active in the cycle the active transfer ends, and no start-of-transfer is raised for it. While the waiting slot is full, further start requests stay pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Channel enable; 0 flushes all queued and running work |
| pause_i | input | 1 | Freezes the active transfer |
| cyclic_i | input | 1 | Cyclic mode: restart on completion |
| start_wr_i | input | 1 | Write strobe for the start bit |
| start_wdata_i | input | 1 | Data written to the start bit |
| len_bytes_i | input | LEN_W | Bytes per row minus 1, captured when a request is taken |
| len_rows_i | input | ROW_W | Rows minus 1, captured when a request is taken |
| mover_err_i | input | 1 | Error strobe from the data mover |
| irq_mask_i | input | 2 | Interrupt mask, 1 blocks the bit |
| irq_clr_i | input | 2 | Write-1-to-clear strobe for the source bits |
| start_pend_o | output | 1 | Start bit readback |
| next_id_o | output | ID_W | ID the next request will receive |
| active_id_o | output | ID_W | ID of the running transfer, or next ID when idle |
| busy_o | output | 1 | A transfer is active |
| done_map_o | output | 2**ID_W | Per-ID completion bitmap |
| irq_src_o | output | 2 | Raw sources: bit 0 start, bit 1 end |
| irq_pend_o | output | 2 | Masked pending bits |
| irq_o | output | 1 | Interrupt line |

## Verification
The assertions assume that `mover_err_i` pulses only while a transfer is active or has no effect otherwise. They also assume that `pause_i` and `enable_i` change only between clock edges. The stimulus drives every input one time unit after the falling edge and sends error pulses only a few cycles into a running transfer. It keeps the lengths small so that completions, queue promotion and the 32-ID wrap all happen within the run. Every output is compared on every cycle against a behavioural model that tracks the waiting slot as a queue and each transfer's remaining time as a plain integer.

// File: rtl/dma_xfer_tracker.sv
module dma_xfer_tracker #(
  parameter int ID_W       = 5,
  parameter int LEN_W      = 16,
  parameter int ROW_W      = 8,
  parameter int BEAT_BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable_i,
  input  logic                 pause_i,
  input  logic                 cyclic_i,
  input  logic                 start_wr_i,
  input  logic                 start_wdata_i,
  input  logic [LEN_W-1:0]     len_bytes_i,
  input  logic [ROW_W-1:0]     len_rows_i,
  input  logic                 mover_err_i,
  input  logic [1:0]           irq_mask_i,
  input  logic [1:0]           irq_clr_i,
  output logic                 start_pend_o,
  output logic [ID_W-1:0]      next_id_o,
  output logic [ID_W-1:0]      active_id_o,
  output logic                 busy_o,
  output logic [(1<<ID_W)-1:0] done_map_o,
  output logic [1:0]           irq_src_o,
  output logic [1:0]           irq_pend_o,
  output logic                 irq_o
);
  localparam int NID   = 1 << ID_W;
  localparam int BSH   = $clog2(BEAT_BYTES);
  localparam int BPR_W = LEN_W - BSH;

  logic             start_q, a_vld, q_vld;
  logic [ID_W-1:0]  nid_q, aid_q, qid_q;
  logic [LEN_W-1:0] a_len, q_len;
  logic [ROW_W-1:0] a_rows, q_rows, row_q;
  logic [BPR_W-1:0] beat_q;
  logic [NID-1:0]   done_q;
  logic [1:0]       src_q;

  wire a_last  = (beat_q == '0) && (row_q == '0);
  wire a_err   = a_vld & mover_err_i;
  wire a_done  = a_vld & ~mover_err_i & ~pause_i & a_last;
  wire restart = a_done & cyclic_i;
  wire free    = ~a_vld | a_err | (a_done & ~cyclic_i);
  wire accept  = enable_i & start_q & ~q_vld;
  wire to_act  = accept & free;
  wire promote = q_vld & free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      a_vld   <= 1'b0;
      q_vld   <= 1'b0;
      nid_q   <= '0;
      aid_q   <= '0;
      qid_q   <= '0;
      a_len   <= '0;
      a_rows  <= '0;
      q_len   <= '0;
      q_rows  <= '0;
      beat_q  <= '0;
      row_q   <= '0;
      done_q  <= '0;
    end else if (!enable_i) begin
      start_q <= 1'b0;
      a_vld   <= 1'b0;
      q_vld   <= 1'b0;
    end else begin
      start_q <= (start_wr_i & start_wdata_i) | (start_q & ~accept);
      if (a_done) done_q[aid_q] <= 1'b1;
      if (accept) begin
        done_q[nid_q] <= 1'b0;
        nid_q         <= nid_q + 1'b1;
      end
      if (to_act) begin
        a_vld  <= 1'b1;
        aid_q  <= nid_q;
        a_len  <= len_bytes_i;
        a_rows <= len_rows_i;
        beat_q <= len_bytes_i[LEN_W-1:BSH];
        row_q  <= len_rows_i;
      end else if (promote) begin
        a_vld  <= 1'b1;
        aid_q  <= qid_q;
        a_len  <= q_len;
        a_rows <= q_rows;
        beat_q <= q_len[LEN_W-1:BSH];
        row_q  <= q_rows;
        q_vld  <= 1'b0;
      end else if (restart) begin
        beat_q <= a_len[LEN_W-1:BSH];
        row_q  <= a_rows;
      end else if (free) begin
        a_vld <= 1'b0;
      end else if (a_vld && !pause_i) begin
        if (beat_q == '0) begin
          beat_q <= a_len[LEN_W-1:BSH];
          row_q  <= row_q - 1'b1;
        end else begin
          beat_q <= beat_q - 1'b1;
        end
      end
      if (accept && !free) begin
        q_vld  <= 1'b1;
        qid_q  <= nid_q;
        q_len  <= len_bytes_i;
        q_rows <= len_rows_i;
      end
    end
  end

  wire [1:0] src_set = enable_i ? {a_err | (a_done & ~cyclic_i), to_act} : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= (src_q & ~irq_clr_i) | src_set;
  end

  assign start_pend_o = start_q;
  assign next_id_o    = nid_q;
  assign busy_o       = a_vld;
  assign active_id_o  = a_vld ? aid_q : nid_q;
  assign done_map_o   = done_q;
  assign irq_src_o    = src_q;
  assign irq_pend_o   = src_q & ~irq_mask_i;
  assign irq_o        = |irq_pend_o;
endmodule

// File: rtl/dma_xfer_tracker_chk.sv
module dma_xfer_tracker_chk #(
  parameter int ID_W = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 enable_i,
  input logic                 pause_i,
  input logic                 mover_err_i,
  input logic                 start_pend_o,
  input logic [ID_W-1:0]      next_id_o,
  input logic [ID_W-1:0]      active_id_o,
  input logic                 busy_o,
  input logic [(1<<ID_W)-1:0] done_map_o,
  input logic [1:0]           irq_src_o
);
  // R1
  id_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_pend_o) && $past(enable_i) |-> next_id_o == $past(next_id_o) + 1'b1);

  // R3
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    next_id_o != $past(next_id_o) |-> !done_map_o[$past(next_id_o)]);

  // R5
  sot_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_src_o[0]) |-> busy_o && $past(start_pend_o));

  // R6
  eot_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_src_o[1]) |-> $past(busy_o));

  // R9
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pause_i && busy_o && !mover_err_i && enable_i |=> busy_o && active_id_o == $past(active_id_o));

  // R10
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !busy_o && !start_pend_o);
endmodule

bind dma_xfer_tracker dma_xfer_tracker_chk #(.ID_W(ID_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .pause_i(pause_i),
  .mover_err_i(mover_err_i), .start_pend_o(start_pend_o), .next_id_o(next_id_o),
  .active_id_o(active_id_o), .busy_o(busy_o), .done_map_o(done_map_o),
  .irq_src_o(irq_src_o)
);

// File: tb/dma_xfer_tracker_tb_top.sv
`timescale 1ns/100ps
module dma_xfer_tracker_tb_top;
  logic clk = 0, rst_n = 0;
  logic en = 0, pause = 0, cyc = 0, swr = 0, swd = 0, err = 0;
  logic [15:0] lb = 0;
  logic [7:0]  lr = 0;
  logic [1:0]  mask = 0, clr = 0;
  logic        st_o, busy_o, irq_o;
  logic [4:0]  nid_o, aid_o;
  logic [31:0] done_o;
  logic [1:0]  src_o, pend_o;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  dma_xfer_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .enable_i(en), .pause_i(pause), .cyclic_i(cyc),
    .start_wr_i(swr), .start_wdata_i(swd), .len_bytes_i(lb), .len_rows_i(lr),
    .mover_err_i(err), .irq_mask_i(mask), .irq_clr_i(clr),
    .start_pend_o(st_o), .next_id_o(nid_o), .active_id_o(aid_o), .busy_o(busy_o),
    .done_map_o(done_o), .irq_src_o(src_o), .irq_pend_o(pend_o), .irq_o(irq_o));

  // behavioural reference
  int act_id, act_left, act_tot, m_nid;
  int pq_id[$], pq_tot[$];
  bit m_sreq;
  logic [31:0] m_done;
  logic [1:0]  m_src;

  always @(posedge clk) begin : mdl
    logic [1:0] set;
    bit fin, efin, fr, acc;
    int t;
    set = 0; fin = 0; efin = 0;
    if (!rst_n) begin
      act_id = -1; act_left = 0; act_tot = 0; m_nid = 0;
      pq_id.delete(); pq_tot.delete(); m_sreq = 0; m_done = 0; m_src = 0;
    end else begin
      if (!en) begin
        act_id = -1; pq_id.delete(); pq_tot.delete(); m_sreq = 0;
      end else begin
        acc = m_sreq && pq_id.size() == 0;
        if (act_id >= 0) begin
          if (err) efin = 1;
          else if (!pause) begin
            if (act_left == 1) fin = 1; else act_left--;
          end
        end
        if (fin) begin
          m_done[act_id] = 1'b1;
          if (cyc) act_left = act_tot; else set[1] = 1'b1;
        end
        if (efin) set[1] = 1'b1;
        fr = act_id < 0 || efin || (fin && !cyc);
        if (fr) begin
          if (pq_id.size() > 0) begin
            act_id = pq_id.pop_front(); act_tot = pq_tot.pop_front(); act_left = act_tot;
          end else act_id = -1;
        end
        if (acc) begin
          t = ((int'(lb) >> 2) + 1) * (int'(lr) + 1);
          if (fr && act_id < 0) begin
            act_id = m_nid; act_tot = t; act_left = t; set[0] = 1'b1;
          end else begin
            pq_id.push_back(m_nid); pq_tot.push_back(t);
          end
          m_done[m_nid] = 1'b0;
          m_nid = (m_nid + 1) % 32;
        end
        m_sreq = (swr && swd) || (m_sreq && !acc);
      end
      m_src = (m_src & ~clr) | set;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(st_o, m_sreq, "R2 start bit");
      chk(nid_o, m_nid, "R1 next id");
      chk(busy_o, act_id >= 0, "R4 busy");
      chk(aid_o, act_id >= 0 ? act_id : m_nid, "R4 active id");
      chk(done_o, m_done, "R3 done map");
      chk(src_o[0], m_src[0], "R5 start source");
      chk(src_o[1], m_src[1], "R6 end source");
      chk(pend_o, m_src & ~mask, "R7 pending");
      chk(irq_o, |(m_src & ~mask), "R7 irq");
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_start(input logic v);
    @(negedge clk); #1 swr = 1; swd = v;
    @(negedge clk); #1 swr = 0; swd = 0;
  endtask

  task automatic pulse_clr(input logic [1:0] v);
    @(negedge clk); #1 clr = v;
    @(negedge clk); #1 clr = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] snap;
    tick(4); #1 rst_n = 1;
    tick(1);
    chk(busy_o, 0, "R4 reset busy");
    chk(nid_o, 0, "R1 reset id");
    chk(done_o, 0, "R3 reset done");
    // start while disabled
    drive_start(1); tick(1);
    chk(st_o, 0, "R2 start ignored when disabled");
    #1 en = 1;
    drive_start(0); tick(1);
    chk(st_o, 0, "R2 write of 0 ignored");
    // single transfer: 2 beats x 2 rows
    #1 lb = 7; lr = 1;
    drive_start(1); tick(12);
    chk(done_o[0], 1, "R3 done after completion");
    chk(src_o, 2'b11, "R5 R6 both sources");
    #1 mask = 2'b01; tick(1);
    chk(pend_o, 2'b10, "R7 masked pending");
    pulse_clr(2'b11); tick(1);
    chk(src_o, 0, "R7 cleared");
    #1 mask = 0;
    // queue two: 4 beats x 4 rows
    #1 lb = 15; lr = 3;
    drive_start(1); tick(2);
    drive_start(1); tick(2);
    chk(st_o, 0, "R11 second request taken into waiting slot");
    chk(aid_o, 1, "R11 first active");
    tick(16);
    chk(aid_o, 2, "R11 waiting request promoted");
    tick(20);
    chk(busy_o, 0, "R11 both finished");
    pulse_clr(2'b11);
    // error termination
    drive_start(1); tick(3);
    @(negedge clk); #1 err = 1; @(negedge clk); #1 err = 0;
    tick(1);
    chk(done_o[3], 0, "R3 error leaves done clear");
    chk(src_o[1], 1, "R6 error raises end");
    pulse_clr(2'b11);
    // pause
    drive_start(1); tick(3);
    #1 pause = 1; tick(40);
    chk(busy_o, 1, "R9 paused transfer held");
    #1 pause = 0; tick(30);
    chk(busy_o, 0, "R9 resumes and completes");
    pulse_clr(2'b11);
    // cyclic
    #1 cyc = 1; lb = 3; lr = 0;
    drive_start(1); tick(20);
    chk(src_o[1], 0, "R8 no end in cyclic");
    chk(busy_o, 1, "R8 restarts");
    chk(done_o[5], 1, "R8 done set");
    drive_start(1); tick(3);
    snap = done_o;
    #1 en = 0; tick(2);
    chk(busy_o, 0, "R10 flushed");
    chk(st_o, 0, "R10 start cleared");
    chk(done_o, snap, "R10 done unchanged");
    #1 cyc = 0; en = 1; lb = 0; lr = 0;
    for (int i = 0; i < 30; i++) begin
      drive_start(1); tick(3);
    end
    chk(nid_o, 5, "R1 id wraps");
    tick(5);
    finish_run();
  end
endmodule